// File: doc/BRIEF.md
# Bidirectional Pad and Function Multiplexer

This block is a register-programmed routing matrix between the chip's digital I/O pads and the signals of the GPIO words and on-chip peripherals. Routing is programmed separately in the two directions. On the output side, every pad has a select register that names the GPIO output or peripheral output that drives it. On the input side, every GPIO input bit and every peripheral input has a select register that names the pad it listens to. A pad's output enable comes from the enable of its selected source. A pad with nothing selected is never driven.

Every pad also has a control register. It holds a receiver enable, pull-up and pull-down requests, an inversion bit and a two-bit drive-strength code, and these go straight to the pad cell. The receiver enable gates the input path. While it is clear, no function input that selects the pad sees its value, and this holds whatever the pad's direction is. The register file has a simple write strobe and a read strobe with one cycle of latency. The crossbars are purely combinational from the stored selects.

The block has no control sequencer. It is a register file feeding two crossbars, so it has no states and no transitions.

Top module: `padmux_matrix`

## Requirements
- R1: Pad p's output-select register is at byte address p*8 and its control register is at p*8+4. A write with reg_wr high takes effect at that clock edge. A read with reg_rd high returns the stored field, zero-extended, on reg_rdata after the next edge, and bits the register does not hold read 0.
- R2: Pads are numbered bank by bank. Bank 0 (5 pads) holds indices 0 to 4, bank 1 (15 pads) holds 5 to 19 and bank 2 (9 pads) holds 20 to 28, so pin n of a bank is pad (bank base + n).
- R3: An output-select code of 0, or any code above the last source, leaves the pad undriven: pad_oe is 0 and pad_out is 0.
- R4: Output-select code 1 + w*16 + b picks GPIO bit w*16+b (gpio_out and gpio_oe). Code NGPIO+1+k picks peripheral output k. pad_out and pad_oe follow the picked source's value and enable.
- R5: The input select for destination d is at byte address 256 + 4*d. GPIO input w*16+b has d = w*16+b and peripheral input k has d = NGPIO+k. Code p+1 picks pad p, and code 0 or any code above the last pad makes the input read 0.
- R6: Control-register bits are: bit 0 receiver enable, bit 1 pull-up, bit 2 pull-down, bit 3 invert, bits 5:4 drive strength. They drive pad_ie, pad_pu, pad_pd and pad_ds for that pad.
- R7: While a pad's receiver enable is clear, every function input that selects it reads 0, even while the pad itself is driven as an output.
- R8: With the invert bit set, the pad value reaching function inputs is inverted and the value driven on pad_out is inverted. pad_oe is not affected.
- R9: Reset clears every register. After reset all pad_oe, gpio_in, per_in and reg_rdata bits are 0.
- R10: Addresses that hold no register (including misaligned ones) read 0, and writes to them change no register. reg_rdata holds its value while reg_rd is low.
- R11: One pad may feed any number of function inputs at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| gpio_out | input | NGPIO | GPIO output values |
| gpio_oe | input | NGPIO | GPIO output enables |
| gpio_in | output | NGPIO | GPIO input values from selected pads |
| per_out | input | PERIPH_OUTS | Peripheral output values |
| per_oe | input | PERIPH_OUTS | Peripheral output enables |
| per_in | output | PERIPH_INS | Peripheral input values from selected pads |
| pad_in | input | NPADS | Values received from the pads |
| pad_out | output | NPADS | Values driven to the pads |
| pad_oe | output | NPADS | Pad output enables |
| pad_ie | output | NPADS | Pad receiver enables |
| pad_pu | output | NPADS | Pull-up requests |
| pad_pd | output | NPADS | Pull-down requests |
| pad_ds | output | 2*NPADS | Drive-strength codes, two bits per pad |

## Verification
The checker watches three things on every cycle. It checks that an unselected pad is never driven. It checks that no function input ever carries a value from a pad whose receiver is disabled. It also checks the pad-0 select write, the read-data hold and the empty state after reset. The bench scenarios are the only place where the numbering is shown. That covers the bank numbering, the GPIO and peripheral source codes, the destination address layout, the inversion on both paths and fan-out from one pad. They also show that unmapped and misaligned addresses are ignored, by reading the neighbouring registers back.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

    // Per-pad control word, bit 0 first from the bottom.
    typedef struct packed {
        logic [1:0] drive;
        logic       invert;
        logic       pull_dn;
        logic       pull_up;
        logic       rx_en;
    } pad_ctl_t;

    localparam int CTL_W = $bits(pad_ctl_t);

endpackage

// File: rtl/padmux_regs.sv
module padmux_regs
    import padmux_pkg::*;
#(
    parameter int NPADS   = 29,
    parameter int NDST    = 36,
    parameter int OSEL_W  = 6,
    parameter int ISEL_W  = 5,
    parameter int ADDR_W  = 10,
    parameter int IN_BASE = 256
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic                               reg_rd,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [31:0]                        reg_wdata,
    output logic [31:0]                        reg_rdata,
    output logic [NPADS-1:0][OSEL_W-1:0]       osel_q,
    output pad_ctl_t [NPADS-1:0]               ctl_q,
    output logic [NDST-1:0][ISEL_W-1:0]        isel_q
);

    logic [31:0] rd_nxt;

    // Pad-side registers: select at p*8, control at p*8+4.
    for (genvar p = 0; p < NPADS; p++) begin : g_pad
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                osel_q[p] <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(p * 8)) begin
                osel_q[p] <= reg_wdata[OSEL_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[p] <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(p * 8 + 4)) begin
                ctl_q[p] <= pad_ctl_t'(reg_wdata[CTL_W-1:0]);
            end
        end
    end

    // Function-side registers: one per destination, 4-byte stride.
    for (genvar d = 0; d < NDST; d++) begin : g_dst
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                isel_q[d] <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(IN_BASE + d * 4)) begin
                isel_q[d] <= reg_wdata[ISEL_W-1:0];
            end
        end
    end

    always_comb begin
        rd_nxt = '0;
        for (int p = 0; p < NPADS; p++) begin
            if (reg_addr == ADDR_W'(p * 8)) begin
                rd_nxt = 32'(osel_q[p]);
            end
            if (reg_addr == ADDR_W'(p * 8 + 4)) begin
                rd_nxt = 32'(ctl_q[p]);
            end
        end
        for (int d = 0; d < NDST; d++) begin
            if (reg_addr == ADDR_W'(IN_BASE + d * 4)) begin
                rd_nxt = 32'(isel_q[d]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_nxt;
        end
    end

endmodule

// File: rtl/padmux_out_xbar.sv
module padmux_out_xbar #(
    parameter int NPADS  = 29,
    parameter int NSRC   = 36,
    parameter int OSEL_W = 6
) (
    input  logic [NSRC-1:0]              src_val,
    input  logic [NSRC-1:0]              src_en,
    input  logic [NPADS-1:0][OSEL_W-1:0] osel,
    input  logic [NPADS-1:0]             inv,
    output logic [NPADS-1:0]             pad_out,
    output logic [NPADS-1:0]             pad_oe
);

    for (genvar p = 0; p < NPADS; p++) begin : g_pad
        logic val;
        logic en;
        logic hit;

        always_comb begin
            val = 1'b0;
            en  = 1'b0;
            hit = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (osel[p] == OSEL_W'(s + 1)) begin
                    val = src_val[s];
                    en  = src_en[s];
                    hit = 1'b1;
                end
            end
        end

        assign pad_out[p] = hit & (val ^ inv[p]);
        assign pad_oe[p]  = hit & en;
    end

endmodule

// File: rtl/padmux_in_xbar.sv
module padmux_in_xbar #(
    parameter int NPADS  = 29,
    parameter int NDST   = 36,
    parameter int ISEL_W = 5
) (
    input  logic [NPADS-1:0]             pad_in,
    input  logic [NPADS-1:0]             ie,
    input  logic [NPADS-1:0]             inv,
    input  logic [NDST-1:0][ISEL_W-1:0]  isel,
    output logic [NDST-1:0]              dst_val
);

    logic [NPADS-1:0] rx;

    // Receiver gate sits before the crossbar, so it covers every listener.
    assign rx = ie & (pad_in ^ inv);

    for (genvar d = 0; d < NDST; d++) begin : g_dst
        always_comb begin
            dst_val[d] = 1'b0;
            for (int p = 0; p < NPADS; p++) begin
                if (isel[d] == ISEL_W'(p + 1)) begin
                    dst_val[d] = rx[p];
                end
            end
        end
    end

endmodule

// File: rtl/padmux_matrix.sv
module padmux_matrix
    import padmux_pkg::*;
#(
    parameter int BANK0_PADS     = 5,
    parameter int BANK1_PADS     = 15,
    parameter int BANK2_PADS     = 9,
    parameter int GPIO_WORDS     = 2,
    parameter int GPIO_WORD_BITS = 16,
    parameter int PERIPH_OUTS    = 4,
    parameter int PERIPH_INS     = 4,
    parameter int ADDR_W         = 10,
    parameter int IN_BASE        = 256,
    localparam int NPADS         = BANK0_PADS + BANK1_PADS + BANK2_PADS,
    localparam int NGPIO         = GPIO_WORDS * GPIO_WORD_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [NGPIO-1:0]        gpio_out,
    input  logic [NGPIO-1:0]        gpio_oe,
    output logic [NGPIO-1:0]        gpio_in,
    input  logic [PERIPH_OUTS-1:0]  per_out,
    input  logic [PERIPH_OUTS-1:0]  per_oe,
    output logic [PERIPH_INS-1:0]   per_in,
    input  logic [NPADS-1:0]        pad_in,
    output logic [NPADS-1:0]        pad_out,
    output logic [NPADS-1:0]        pad_oe,
    output logic [NPADS-1:0]        pad_ie,
    output logic [NPADS-1:0]        pad_pu,
    output logic [NPADS-1:0]        pad_pd,
    output logic [2*NPADS-1:0]      pad_ds
);

    localparam int NSRC   = NGPIO + PERIPH_OUTS;
    localparam int NDST   = NGPIO + PERIPH_INS;
    localparam int OSEL_W = $clog2(NSRC + 1);
    localparam int ISEL_W = $clog2(NPADS + 1);

    logic [NPADS-1:0][OSEL_W-1:0] osel;
    pad_ctl_t [NPADS-1:0]         ctl;
    logic [NDST-1:0][ISEL_W-1:0]  isel;
    logic [NPADS-1:0]             inv;
    logic [NDST-1:0]              dst_val;

    padmux_regs #(
        .NPADS  (NPADS),
        .NDST   (NDST),
        .OSEL_W (OSEL_W),
        .ISEL_W (ISEL_W),
        .ADDR_W (ADDR_W),
        .IN_BASE(IN_BASE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .osel_q   (osel),
        .ctl_q    (ctl),
        .isel_q   (isel)
    );

    for (genvar p = 0; p < NPADS; p++) begin : g_ctl
        assign pad_ie[p]         = ctl[p].rx_en;
        assign pad_pu[p]         = ctl[p].pull_up;
        assign pad_pd[p]         = ctl[p].pull_dn;
        assign inv[p]            = ctl[p].invert;
        assign pad_ds[2*p +: 2]  = ctl[p].drive;
    end

    padmux_out_xbar #(
        .NPADS (NPADS),
        .NSRC  (NSRC),
        .OSEL_W(OSEL_W)
    ) u_out (
        .src_val({per_out, gpio_out}),
        .src_en ({per_oe, gpio_oe}),
        .osel   (osel),
        .inv    (inv),
        .pad_out(pad_out),
        .pad_oe (pad_oe)
    );

    padmux_in_xbar #(
        .NPADS (NPADS),
        .NDST  (NDST),
        .ISEL_W(ISEL_W)
    ) u_in (
        .pad_in (pad_in),
        .ie     (pad_ie),
        .inv    (inv),
        .isel   (isel),
        .dst_val(dst_val)
    );

    assign gpio_in = dst_val[NGPIO-1:0];
    assign per_in  = dst_val[NGPIO +: PERIPH_INS];

endmodule

// File: rtl/padmux_matrix_chk.sv
module padmux_matrix_chk #(
    parameter int NPADS  = 29,
    parameter int NDST   = 36,
    parameter int OSEL_W = 6,
    parameter int ISEL_W = 5,
    parameter int ADDR_W = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              reg_wr,
    input logic                              reg_rd,
    input logic [ADDR_W-1:0]                 reg_addr,
    input logic [31:0]                       reg_wdata,
    input logic [31:0]                       reg_rdata,
    input logic [NPADS-1:0][OSEL_W-1:0]      osel,
    input logic [NDST-1:0][ISEL_W-1:0]       isel,
    input logic [NPADS-1:0]                  pad_ie,
    input logic [NPADS-1:0]                  pad_oe,
    input logic [NDST-1:0]                   dst_val
);

    logic [NDST-1:0] leak;

    always_comb begin
        leak = '0;
        for (int d = 0; d < NDST; d++) begin
            for (int p = 0; p < NPADS; p++) begin
                if (isel[d] == ISEL_W'(p + 1) && !pad_ie[p] && dst_val[d]) begin
                    leak[d] = 1'b1;
                end
            end
        end
    end

    // R3: an unselected pad is never driven
    for (genvar p = 0; p < NPADS; p++) begin : g_pad
        p_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (osel[p] == '0) |-> !pad_oe[p]);
    end

    p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        leak == '0);

    p_sel_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0) |=> (osel[0] == $past(reg_wdata[OSEL_W-1:0])));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    p_reset_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && dst_val == '0));

endmodule

bind padmux_matrix padmux_matrix_chk #(
    .NPADS (NPADS),
    .NDST  (NDST),
    .OSEL_W(OSEL_W),
    .ISEL_W(ISEL_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .osel     (osel),
    .isel     (isel),
    .pad_ie   (pad_ie),
    .pad_oe   (pad_oe),
    .dst_val  ({per_in, gpio_in})
);

// File: tb/padmux_matrix_tb.sv
module padmux_matrix_tb;

    localparam int NPADS  = 29;
    localparam int NGPIO  = 32;
    localparam int NPO    = 4;
    localparam int NPI    = 4;
    localparam int ADDR_W = 10;
    localparam int INB    = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NGPIO-1:0]  gpio_out = '0;
    logic [NGPIO-1:0]  gpio_oe = '0;
    logic [NGPIO-1:0]  gpio_in;
    logic [NPO-1:0]    per_out = '0;
    logic [NPO-1:0]    per_oe = '0;
    logic [NPI-1:0]    per_in;
    logic [NPADS-1:0]  pad_in = '0;
    logic [NPADS-1:0]  pad_out;
    logic [NPADS-1:0]  pad_oe;
    logic [NPADS-1:0]  pad_ie;
    logic [NPADS-1:0]  pad_pu;
    logic [NPADS-1:0]  pad_pd;
    logic [2*NPADS-1:0] pad_ds;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    padmux_matrix u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_ie(pad_ie), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ds(pad_ds)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_addr  = ADDR_W'(addr);
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        reg_addr = ADDR_W'(addr);
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        data     = reg_rdata;
    endtask

    task automatic t_reset();
        chk("R9 pad_oe after reset", 32'(pad_oe), 0);
        chk("R9 gpio_in after reset", gpio_in, 0);
        chk("R9 per_in after reset", 32'(per_in), 0);
        chk("R9 rdata after reset", reg_rdata, 0);
    endtask

    task automatic t_ctl();
        logic [31:0] v;
        wr(28 * 8 + 4, 32'h36);   // ds=3, pd=1, pu=1, rx off
        #1;
        chk("R6 pad_pu[28]", 32'(pad_pu[28]), 1);
        chk("R6 pad_pd[28]", 32'(pad_pd[28]), 1);
        chk("R6 pad_ie[28]", 32'(pad_ie[28]), 0);
        chk("R6 pad_ds[28]", 32'(pad_ds[57:56]), 3);
        rd(28 * 8 + 4, v);
        chk("R1 ctl readback", v, 32'h36);
        wr(28 * 8 + 4, 32'hFFFF_FFC1);
        rd(28 * 8 + 4, v);
        chk("R1 ctl unused bits read 0", v, 32'h01);
        @(negedge clk);
        chk("R10 rdata held without read", reg_rdata, 32'h01);
    endtask

    task automatic t_out_route();
        logic [31:0] v;
        // R2: bank 2 pin 3 is pad 23; R4: gpio 17 is code 18
        wr(23 * 8, 18);
        gpio_out[17] = 1'b1;
        gpio_oe[17]  = 1'b1;
        #1;
        chk("R4 pad_out[23] from gpio 17", 32'(pad_out[23]), 1);
        chk("R4 pad_oe[23] from gpio 17", 32'(pad_oe[23]), 1);
        gpio_out[17] = 1'b0;
        gpio_oe[17]  = 1'b0;
        #1;
        chk("R4 pad_out[23] follows", 32'(pad_out[23]), 0);
        chk("R4 pad_oe[23] follows", 32'(pad_oe[23]), 0);
        // R2: bank 1 pin 0 is pad 5; peripheral output 2 is code 35
        wr(5 * 8, 35);
        per_out[2] = 1'b1;
        per_oe[2]  = 1'b1;
        #1;
        chk("R2 R4 pad 5 from periph 2", {30'd0, pad_oe[5], pad_out[5]}, 3);
        rd(5 * 8, v);
        chk("R1 sel readback pad 5", v, 35);
        wr(5 * 8, 63);
        #1;
        chk("R3 out-of-range code leaves pad 5 off", {30'd0, pad_oe[5], pad_out[5]}, 0);
        wr(5 * 8, 0);
        #1;
        chk("R3 code 0 leaves pad 5 off", {30'd0, pad_oe[5], pad_out[5]}, 0);
    endtask

    task automatic t_in_route();
        wr(7 * 8 + 4, 1);          // rx enable on pad 7
        wr(INB + 3 * 4, 8);        // gpio input 3 <- pad 7
        pad_in[7] = 1'b1;
        #1;
        chk("R5 gpio_in[3] from pad 7", 32'(gpio_in[3]), 1);
        wr(INB + (NGPIO + 1) * 4, 8);   // peripheral input 1 <- pad 7
        #1;
        chk("R11 per_in[1] shares pad 7", 32'(per_in[1]), 1);
        chk("R11 gpio_in[3] still pad 7", 32'(gpio_in[3]), 1);
        pad_in[7] = 1'b0;
        #1;
        chk("R5 gpio_in[3] follows pad", 32'(gpio_in[3]), 0);
        pad_in[7] = 1'b1;
        wr(INB + (NGPIO + 1) * 4, 30);  // beyond last pad
        #1;
        chk("R5 out-of-range input code reads 0", 32'(per_in[1]), 0);
    endtask

    task automatic t_rx_gate();
        wr(7 * 8 + 4, 0);          // rx off
        #1;
        chk("R7 rx off gates gpio_in[3]", 32'(gpio_in[3]), 0);
        wr(7 * 8, 1);              // drive pad 7 from gpio 0
        gpio_out[0] = 1'b1;
        gpio_oe[0]  = 1'b1;
        #1;
        chk("R7 rx off gates while pad driven", 32'(gpio_in[3]), 0);
    endtask

    task automatic t_invert();
        wr(7 * 8 + 4, 32'h9);      // rx on, invert
        pad_in[7] = 1'b1;
        #1;
        chk("R8 inverted input high->0", 32'(gpio_in[3]), 0);
        chk("R8 inverted output", 32'(pad_out[7]), 0);
        chk("R8 oe not inverted", 32'(pad_oe[7]), 1);
        pad_in[7] = 1'b0;
        #1;
        chk("R8 inverted input low->1", 32'(gpio_in[3]), 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(0, 12);
        wr(NPADS * 8, 5);          // past the last pad
        rd(NPADS * 8, v);
        chk("R10 unmapped reads 0", v, 0);
        wr(2, 7);                  // misaligned
        rd(0, v);
        chk("R10 misaligned write ignored", v, 12);
        rd(4, v);
        chk("R10 neighbour ctl untouched", v, 0);
        rd(INB + (NGPIO + NPI) * 4, v);
        chk("R10 past last input select reads 0", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_out_route();
        t_in_route();
        t_rx_gate();
        t_invert();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule